// File: doc/BRIEF.md
# Reference Holdover State Machine

This block supervises the external frequency reference of a timebase and decides whether the steering loop may follow it or must coast on its last setting. It watches three health inputs: reference present, upstream lock and quality good. A loss is acted on only once it has lasted a full debounce window. When that happens, the block freezes the steering word. It also records a snapshot of the steering word, the temperature, the source identifier and a timestamp, and it issues a single event strobe with a cause code.

Recovery takes two steps. First a reacquire phase, with Holdover still asserted, requires the reference to stay clean for a qualification window. Then a settling phase releases the loop but keeps the in-spec flag low until a programmable run of consecutive in-tolerance samples has been seen. A minimum dwell in holdover prevents the block from toggling back and forth on a marginal reference. Two counters are available at the ports: the number of reacquire attempts and the number of cycles spent in holdover, both for the most recent loss episode. A low-headroom alarm is latched when the frozen steering word is close to either end of its range.

Top module: `ref_holdover_fsm`

## Requirements
- R1: While reset is asserted, holdover, reacquire, to_spec, freeze, evt_stb, hr_alarm, reacq_tries and hold_cycles are all 0. After reset the block is in the settling state.
- R2: A fault (any of ref_present, up_lock, qual_ok low) seen in the locked or settling state enters holdover only after DEB_CYC consecutive fault cycles. A shorter fault has no effect.
- R3: On holdover entry, holdover and freeze rise at the same clock edge and evt_stb is high for exactly one cycle.
- R4: evt_reason during evt_stb is 1 when ref_present is low, 2 when it is present but up_lock is low, and 3 when both are good but qual_ok is low. The code with the lower number wins.
- R5: snap_efc, snap_temp, snap_src and snap_ts take the input values sampled at the entry edge and keep them until the next entry.
- R6: At entry, hr_alarm is set when the steering word is below HEADROOM or above (2^EFC_W-1)-HEADROOM, and cleared otherwise. It is also cleared when the block returns to locked.
- R7: The reacquire flag rises no sooner than MIN_DWELL+1 cycles after holdover entry or re-entry, even with a clean reference.
- R8: In reacquire, holdover and reacquire are both 1. REACQ_CYC consecutive clean cycles move the block to settling. Any fault returns it to holdover only (reacquire 0, holdover 1) with no new event.
- R9: In settling, holdover, reacquire and to_spec are 0. to_spec rises after settle_need consecutive cycles with in_tol high. An out-of-tolerance cycle restarts the count, and a settle_need of 0 acts as 1.
- R10: In locked, to_spec is 1 and in_tol has no effect.
- R11: reacq_tries clears at holdover entry and increments each time reacquire begins.
- R12: hold_cycles clears at holdover entry, increments for every cycle that holdover is asserted, and holds its value in settling and locked.
- R13: freeze is 1 in holdover and reacquire and 0 in settling and locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_present | input | 1 | Reference signal detected |
| up_lock | input | 1 | Upstream source reports lock |
| qual_ok | input | 1 | Reference quality within limits |
| in_tol | input | 1 | Current frequency sample within tolerance |
| settle_need | input | CNT_W | Consecutive in-tolerance samples needed for to_spec |
| efc_word | input | EFC_W | Live steering word |
| temp_word | input | TEMP_W | Live temperature reading |
| src_id | input | SRC_W | Active reference identifier |
| tstamp | input | TS_W | Free-running timestamp |
| holdover | output | 1 | Coasting on frozen steering |
| reacquire | output | 1 | Qualifying a returned reference |
| to_spec | output | 1 | Output meets specification |
| freeze | output | 1 | Hold the steering word |
| evt_stb | output | 1 | One-cycle reference-lost event |
| evt_reason | output | 2 | Cause code of the last event |
| snap_efc | output | EFC_W | Steering word at entry |
| snap_temp | output | TEMP_W | Temperature at entry |
| snap_src | output | SRC_W | Source identifier at entry |
| snap_ts | output | TS_W | Timestamp at entry |
| hr_alarm | output | 1 | Low steering headroom at entry |
| reacq_tries | output | CNT_W | Reacquire attempts this episode |
| hold_cycles | output | DUR_W | Cycles spent in holdover this episode |

## Verification
The properties assume that every input is synchronous to clk and holds a known value from the release of reset onward. They also assume that settle_need only changes while the block is not settling, so a run-length count never has its limit moved under it. The bench meets these conditions by changing inputs one nanosecond after a rising edge and by setting settle_need before each recovery begins. Every fault episode is set up so that the entry edge, the dwell end and the settling end fall at cycle counts that can be predicted exactly.

// File: rtl/rhf_pkg.sv
`timescale 1ns/1ps
package rhf_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HOLD   = 2'd1,
    ST_REACQ  = 2'd2,
    ST_SETTLE = 2'd3
  } rhf_state_e;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_ABSENT  = 2'd1,
    RSN_UNLOCK  = 2'd2,
    RSN_QUALITY = 2'd3
  } rhf_reason_e;

  // lowest code wins: absence outranks unlock outranks quality
  function automatic rhf_reason_e rhf_classify(input logic present,
                                               input logic locked,
                                               input logic qual);
    rhf_reason_e r;
    if (!present)     r = RSN_ABSENT;
    else if (!locked) r = RSN_UNLOCK;
    else if (!qual)   r = RSN_QUALITY;
    else              r = RSN_NONE;
    return r;
  endfunction

endpackage

// File: rtl/rhf_runlen.sv
`timescale 1ns/1ps
// Consecutive-cycle run counter: hit while run has been high for 'limit' cycles.
module rhf_runlen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt_q, cnt_d, lim_m1;

  always_comb begin
    lim_m1 = (limit == '0) ? '0 : limit - 1'b1;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                cnt_d = '0;
    else if (cnt_q < lim_m1) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = run && (cnt_q >= lim_m1);

endmodule

// File: rtl/rhf_satcnt.sv
`timescale 1ns/1ps
// Saturating event counter with synchronous clear taking priority.
module rhf_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)                    cnt_d = '0;
    else if (inc && cnt != TOP) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

endmodule

// File: rtl/rhf_snap.sv
`timescale 1ns/1ps
// Last-known-good capture and steering headroom check.
module rhf_snap #(
  parameter int EFC_W    = 16,
  parameter int TEMP_W   = 12,
  parameter int SRC_W    = 3,
  parameter int TS_W     = 32,
  parameter int HEADROOM = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              clr_alarm,
  input  logic [EFC_W-1:0]  efc_word,
  input  logic [TEMP_W-1:0] temp_word,
  input  logic [SRC_W-1:0]  src_id,
  input  logic [TS_W-1:0]   tstamp,
  output logic [EFC_W-1:0]  snap_efc,
  output logic [TEMP_W-1:0] snap_temp,
  output logic [SRC_W-1:0]  snap_src,
  output logic [TS_W-1:0]   snap_ts,
  output logic              hr_alarm
);

  localparam logic [EFC_W-1:0] EFC_TOP = {EFC_W{1'b1}};
  localparam logic [EFC_W-1:0] HR_LO   = EFC_W'(HEADROOM);
  localparam logic [EFC_W-1:0] HR_HI   = EFC_TOP - HR_LO;

  logic near_rail;

  always_comb begin
    near_rail = (efc_word < HR_LO) || (efc_word > HR_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_efc  <= '0;
      snap_temp <= '0;
      snap_src  <= '0;
      snap_ts   <= '0;
    end else if (capture) begin
      snap_efc  <= efc_word;
      snap_temp <= temp_word;
      snap_src  <= src_id;
      snap_ts   <= tstamp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hr_alarm <= 1'b0;
    else if (capture)   hr_alarm <= near_rail;
    else if (clr_alarm) hr_alarm <= 1'b0;
  end

endmodule

// File: rtl/ref_holdover_fsm.sv
`timescale 1ns/1ps
module ref_holdover_fsm
  import rhf_pkg::*;
#(
  parameter int EFC_W     = 16,
  parameter int TEMP_W    = 12,
  parameter int SRC_W     = 3,
  parameter int TS_W      = 32,
  parameter int CNT_W     = 16,
  parameter int DUR_W     = 24,
  parameter int DEB_CYC   = 8,
  parameter int MIN_DWELL = 16,
  parameter int REACQ_CYC = 12,
  parameter int HEADROOM  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_present,
  input  logic              up_lock,
  input  logic              qual_ok,
  input  logic              in_tol,
  input  logic [CNT_W-1:0]  settle_need,
  input  logic [EFC_W-1:0]  efc_word,
  input  logic [TEMP_W-1:0] temp_word,
  input  logic [SRC_W-1:0]  src_id,
  input  logic [TS_W-1:0]   tstamp,
  output logic              holdover,
  output logic              reacquire,
  output logic              to_spec,
  output logic              freeze,
  output logic              evt_stb,
  output logic [1:0]        evt_reason,
  output logic [EFC_W-1:0]  snap_efc,
  output logic [TEMP_W-1:0] snap_temp,
  output logic [SRC_W-1:0]  snap_src,
  output logic [TS_W-1:0]   snap_ts,
  output logic              hr_alarm,
  output logic [CNT_W-1:0]  reacq_tries,
  output logic [DUR_W-1:0]  hold_cycles
);

  localparam logic [CNT_W-1:0] DEB_LIM   = CNT_W'(DEB_CYC);
  localparam logic [CNT_W-1:0] DWELL_LIM = CNT_W'(MIN_DWELL + 1);
  localparam logic [CNT_W-1:0] QUAL_LIM  = CNT_W'(REACQ_CYC);

  rhf_state_e st_q, st_d;
  logic fault, confirm, dwell_hit, qual_hit, settle_hit;
  logic watch_loss, in_hold, in_reacq, in_settle, start_reacq;
  rhf_reason_e cause;

  always_comb begin
    fault      = !(ref_present && up_lock && qual_ok);
    cause      = rhf_classify(ref_present, up_lock, qual_ok);
    in_hold    = (st_q == ST_HOLD);
    in_reacq   = (st_q == ST_REACQ);
    in_settle  = (st_q == ST_SETTLE);
    watch_loss = (st_q == ST_LOCKED) || in_settle;
  end

  // loss debounce, dwell timer, reacquire qualification, settling gate
  rhf_runlen #(.W(CNT_W)) deb_i (
    .clk(clk), .rst_n(rst_n), .run(watch_loss && fault),
    .limit(DEB_LIM), .hit(confirm));

  rhf_runlen #(.W(CNT_W)) dwell_i (
    .clk(clk), .rst_n(rst_n), .run(in_hold),
    .limit(DWELL_LIM), .hit(dwell_hit));

  rhf_runlen #(.W(CNT_W)) qual_i (
    .clk(clk), .rst_n(rst_n), .run(in_reacq && !fault),
    .limit(QUAL_LIM), .hit(qual_hit));

  rhf_runlen #(.W(CNT_W)) settle_i (
    .clk(clk), .rst_n(rst_n), .run(in_settle && in_tol),
    .limit(settle_need), .hit(settle_hit));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LOCKED: if (confirm) st_d = ST_HOLD;
      ST_SETTLE: begin
        if (confirm)         st_d = ST_HOLD;
        else if (settle_hit) st_d = ST_LOCKED;
      end
      ST_HOLD:   if (dwell_hit && !fault) st_d = ST_REACQ;
      ST_REACQ: begin
        if (fault)         st_d = ST_HOLD;
        else if (qual_hit) st_d = ST_SETTLE;
      end
      default:   st_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SETTLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_stb    <= 1'b0;
      evt_reason <= RSN_NONE;
    end else begin
      evt_stb <= confirm;
      if (confirm) evt_reason <= cause;
    end
  end

  always_comb begin
    holdover    = in_hold || in_reacq;
    freeze      = (st_q == ST_HOLD) || (st_q == ST_REACQ);
    reacquire   = in_reacq;
    to_spec     = (st_q == ST_LOCKED);
    start_reacq = in_hold && (st_d == ST_REACQ);
  end

  rhf_snap #(
    .EFC_W(EFC_W), .TEMP_W(TEMP_W), .SRC_W(SRC_W), .TS_W(TS_W),
    .HEADROOM(HEADROOM)
  ) snap_i (
    .clk(clk), .rst_n(rst_n), .capture(confirm),
    .clr_alarm(in_settle && (st_d == ST_LOCKED)),
    .efc_word(efc_word), .temp_word(temp_word), .src_id(src_id),
    .tstamp(tstamp), .snap_efc(snap_efc), .snap_temp(snap_temp),
    .snap_src(snap_src), .snap_ts(snap_ts), .hr_alarm(hr_alarm));

  rhf_satcnt #(.W(CNT_W)) tries_i (
    .clk(clk), .rst_n(rst_n), .clr(confirm), .inc(start_reacq),
    .cnt(reacq_tries));

  rhf_satcnt #(.W(DUR_W)) dur_i (
    .clk(clk), .rst_n(rst_n), .clr(confirm), .inc(holdover),
    .cnt(hold_cycles));

endmodule

// File: rtl/rhf_chk.sv
`timescale 1ns/1ps
module rhf_chk #(
  parameter int EFC_W   = 16,
  parameter int DEB_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_present,
  input logic             up_lock,
  input logic             qual_ok,
  input logic             in_tol,
  input logic             holdover,
  input logic             reacquire,
  input logic             to_spec,
  input logic             freeze,
  input logic             evt_stb,
  input logic [1:0]       evt_reason,
  input logic [EFC_W-1:0] snap_efc
);

  logic [15:0] flt_run;
  logic        flt_now;

  always_comb flt_now = !(ref_present && up_lock && qual_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flt_run <= '0;
    else if (!flt_now)         flt_run <= '0;
    else if (flt_run != 16'hFFFF) flt_run <= flt_run + 1'b1;
  end

  p_evt_debounced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> (flt_run >= 16'(DEB_CYC)));

  p_entry_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover) |-> evt_stb);

  p_evt_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |=> !evt_stb);

  p_evt_reason_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |-> (evt_reason != 2'd0) && holdover && !reacquire);

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover && !evt_stb) |-> $stable(snap_efc));

  p_reacq_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reacquire |-> holdover);

  p_spec_not_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    to_spec |-> !holdover && !reacquire);

  p_spec_rise_tol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_spec) |-> $past(in_tol));

  p_freeze_mode_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> evt_stb);

endmodule

bind ref_holdover_fsm rhf_chk #(.EFC_W(EFC_W), .DEB_CYC(DEB_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ref_present(ref_present), .up_lock(up_lock),
  .qual_ok(qual_ok), .in_tol(in_tol), .holdover(holdover),
  .reacquire(reacquire), .to_spec(to_spec), .freeze(freeze),
  .evt_stb(evt_stb), .evt_reason(evt_reason), .snap_efc(snap_efc));

// File: tb/ref_holdover_fsm_tb_top.sv
`timescale 1ns/1ps
module ref_holdover_fsm_tb_top;

  localparam int D = 8;
  localparam int M = 16;
  localparam int Q = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_present, up_lock, qual_ok, in_tol;
  logic [15:0] settle_need;
  logic [15:0] efc_word;
  logic [11:0] temp_word;
  logic [2:0]  src_id;
  logic [31:0] tstamp;
  logic        holdover, reacquire, to_spec, freeze, evt_stb, hr_alarm;
  logic [1:0]  evt_reason;
  logic [15:0] snap_efc, reacq_tries;
  logic [11:0] snap_temp;
  logic [2:0]  snap_src;
  logic [31:0] snap_ts;
  logic [23:0] hold_cycles;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ref_holdover_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .ref_present(ref_present), .up_lock(up_lock),
    .qual_ok(qual_ok), .in_tol(in_tol), .settle_need(settle_need),
    .efc_word(efc_word), .temp_word(temp_word), .src_id(src_id),
    .tstamp(tstamp), .holdover(holdover), .reacquire(reacquire),
    .to_spec(to_spec), .freeze(freeze), .evt_stb(evt_stb),
    .evt_reason(evt_reason), .snap_efc(snap_efc), .snap_temp(snap_temp),
    .snap_src(snap_src), .snap_ts(snap_ts), .hr_alarm(hr_alarm),
    .reacq_tries(reacq_tries), .hold_cycles(hold_cycles));

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic flags(input string req, input logic h, input logic r,
                       input logic s, input logic f);
    check(req, "holdover", holdover, h);
    check(req, "reacquire", reacquire, r);
    check(req, "to_spec", to_spec, s);
    check(req, "freeze", freeze, f);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ref_present = 1; up_lock = 1; qual_ok = 1; in_tol = 0;
    settle_need = 16'd4; efc_word = 16'h8000; temp_word = 12'h100;
    src_id = 3'd1; tstamp = 32'd0;
    step(3);
    flags("R1", 0, 0, 0, 0);
    check("R1", "evt_stb", evt_stb, 0);
    check("R1", "hr_alarm", hr_alarm, 0);
    check("R1", "reacq_tries", reacq_tries, 0);
    check("R1", "hold_cycles", hold_cycles, 0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_settle_from_reset();
    in_tol = 1;
    step(2);
    check("R9", "to_spec early", to_spec, 0);
    in_tol = 0;
    step(1);
    in_tol = 1;
    step(3);
    flags("R9", 0, 0, 0, 0);
    step(1);
    check("R9", "to_spec after run", to_spec, 1);
    in_tol = 0;
    step(5);
    check("R10", "to_spec ignores in_tol", to_spec, 1);
  endtask

  task automatic t_glitch();
    ref_present = 0;
    step(D - 1);
    check("R2", "holdover short fault", holdover, 0);
    ref_present = 1;
    for (int i = 0; i < D; i++) begin
      step(1);
      check("R2", "no event on glitch", evt_stb, 0);
    end
    check("R2", "to_spec kept", to_spec, 1);
  endtask

  task automatic t_enter_and_recover();
    efc_word = 16'h0100; temp_word = 12'h3A5; src_id = 3'd5;
    tstamp = 32'hDEAD0001;
    ref_present = 0; up_lock = 0;
    step(D - 1);
    check("R2", "not yet in holdover", holdover, 0);
    step(1);
    flags("R3", 1, 0, 0, 1);
    check("R3", "evt_stb", evt_stb, 1);
    check("R4", "reason absent", evt_reason, 1);
    check("R5", "snap_efc", snap_efc, 16'h0100);
    check("R5", "snap_temp", snap_temp, 12'h3A5);
    check("R5", "snap_src", snap_src, 5);
    check("R5", "snap_ts", snap_ts, 32'hDEAD0001);
    check("R6", "alarm low rail", hr_alarm, 1);
    check("R11", "tries cleared", reacq_tries, 0);
    check("R12", "duration cleared", hold_cycles, 0);
    efc_word = 16'h7777; tstamp = 32'h1;
    ref_present = 1; up_lock = 1; in_tol = 1; settle_need = 16'd4;
    step(1);
    check("R3", "evt one cycle", evt_stb, 0);
    check("R5", "snap_efc held", snap_efc, 16'h0100);
    check("R12", "duration 1", hold_cycles, 1);
    step(M - 1);
    check("R7", "dwell holds reacquire", reacquire, 0);
    check("R13", "freeze in holdover", freeze, 1);
    step(1);
    flags("R8", 1, 1, 0, 1);
    check("R11", "tries 1", reacq_tries, 1);
    step(Q - 1);
    check("R8", "still reacquire", reacquire, 1);
    step(1);
    flags("R9", 0, 0, 0, 0);
    check("R12", "duration total", hold_cycles, M + 1 + Q);
    step(3);
    check("R9", "to_spec waits", to_spec, 0);
    step(1);
    check("R10", "locked to_spec", to_spec, 1);
    check("R6", "alarm cleared at lock", hr_alarm, 0);
    check("R12", "duration held", hold_cycles, M + 1 + Q);
    check("R5", "snap_efc kept after lock", snap_efc, 16'h0100);
  endtask

  task automatic t_unlock_abort();
    efc_word = 16'h8000; src_id = 3'd2;
    up_lock = 0;
    step(D);
    check("R4", "reason unlock", evt_reason, 2);
    check("R6", "no alarm mid range", hr_alarm, 0);
    check("R5", "new snapshot", snap_efc, 16'h8000);
    check("R11", "tries cleared again", reacq_tries, 0);
    up_lock = 1; settle_need = 16'd0;
    step(M + 1);
    check("R8", "reacquire rose", reacquire, 1);
    qual_ok = 0;
    step(1);
    flags("R8", 1, 0, 0, 1);
    check("R8", "no event on abort", evt_stb, 0);
    qual_ok = 1;
    step(M);
    check("R7", "dwell restarted", reacquire, 0);
    step(1);
    check("R7", "reacquire after dwell", reacquire, 1);
    check("R11", "tries 2", reacq_tries, 2);
    step(Q);
    flags("R9", 0, 0, 0, 0);
    step(1);
    check("R9", "zero need acts as one", to_spec, 1);
  endtask

  task automatic t_quality();
    efc_word = 16'hFF00;
    qual_ok = 0;
    step(D);
    check("R4", "reason quality", evt_reason, 3);
    check("R6", "alarm high rail", hr_alarm, 1);
    check("R13", "freeze at entry", freeze, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_settle_from_reset();
    t_glitch();
    t_enter_and_recover();
    t_unlock_abort();
    t_quality();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule